// File: doc/BRIEF.md
# Power-On Strap Capture and Frequency Source Select

This block samples a small group of shared board pins while power-on reset is held. On the same pins, the board ties pull resistors that set the configuration. The three low pins carry the frequency code, the next pin carries the desktop/mobile mode, and the top pin carries the CPU buffer supply choice.

While reset is active the block keeps every shared pad in high impedance, so the pull resistors alone set the level. On the first clock edge after reset is released, it enables the pad drivers so that the pins carry clocks from then on. The captured values stay fixed until the next power-on reset.

After reset the block delivers the active 3-bit frequency code. Software chooses where that code comes from with a source-select bit. With the bit clear, the code is the captured strap value. With the bit set, the code is a software field. The block also exposes the frequency straps for readback in inverted polarity. It drives the mode flag that decides whether two further pins are clock outputs (desktop) or stop inputs (mobile).

Top module: `boot_strap_select`

## Requirements
- R1: While `por_n` is low, every bit of `pad_oe` and of `stop_pin_oe` is 0 (pads in high impedance).
- R2: `pad_oe` is 0 until the first rising clock edge at which `por_n` is sampled high, and all ones from that edge on, for as long as `por_n` stays high.
- R3: At every rising edge with `por_n` low, the block samples `pad_in`. The captured value is the one present at the last such edge before release.
- R4: After release, changes on `pad_in` have no effect on `freq_code`, `fs_rb_n`, `desktop_mode` or `cpu_lowv`.
- R5: With `cfg_src_sw` = 0, `freq_code` equals the captured `pad_in[2:0]`. Code 3'b111 is the fastest setting and 3'b000 is the slowest.
- R6: With `cfg_src_sw` = 1, `freq_code` equals `cfg_freq_sw` in the same cycle. Changing `cfg_src_sw` switches the source without a clock of delay.
- R7: `fs_rb_n` is the bitwise inverse of the captured `pad_in[2:0]`, whatever the source select.
- R8: `desktop_mode` equals the captured `pad_in[3]` (1 = desktop). `stop_pin_oe` is all ones only when `pad_oe` is enabled and `desktop_mode` is 1. Otherwise it is 0 and the two pins stay stop inputs.
- R9: `cpu_lowv` equals the captured `pad_in[4]` (1 = 2.5 V CPU buffers, 0 = 3.3 V).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| pad_in | input | FS_W+2 | Levels seen on the shared strap pads: [2:0] code, [3] mode, [4] supply |
| cfg_src_sw | input | 1 | Frequency source: 0 straps, 1 software field |
| cfg_freq_sw | input | FS_W | Software frequency code |
| pad_oe | output | FS_W+2 | Output enable of the shared strap pads |
| stop_pin_oe | output | STOP_W | Output enable of the two mode-shared pins |
| freq_code | output | FS_W | Active frequency code |
| fs_rb_n | output | FS_W | Inverted readback of the captured code straps |
| desktop_mode | output | 1 | Captured mode strap |
| cpu_lowv | output | 1 | Captured CPU supply strap |

## Verification
Two functions share the release cycle. The last strap capture and the turn-on of the pad drivers sit on adjacent edges, and a pad level that changes right at release must not reach the latch. The bench provokes this by driving the inverse pattern onto `pad_in` at the very moment `por_n` rises. It also moves `cfg_src_sw` in that cycle. It then checks that the drivers are still off before the next edge and fully on after it, that the captured straps match the pre-release pattern, and that `freq_code` follows whichever source is selected at that moment.

// File: rtl/strap_pkg.sv
package strap_pkg;
   // Layout of the strap vector: code bits low, then mode, then supply.
   function automatic int unsigned mode_pos(input int unsigned fs_w);
      return fs_w;
   endfunction

   function automatic int unsigned supply_pos(input int unsigned fs_w);
      return fs_w + 1;
   endfunction

   function automatic int unsigned pad_width(input int unsigned fs_w);
      return fs_w + 2;
   endfunction
endpackage

// File: rtl/strap_latch.sv
module strap_latch #(
   parameter int unsigned W = 5
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic [W-1:0] pad_in,
   output logic [W-1:0] strap_q
);
   generate
      if (W < 3) begin : g_bad_w
         $error("strap_latch: W must be at least 3");
      end
   endgenerate

   // Track the pads on every edge of reset; freeze once reset is gone.
   always_ff @(posedge clk) begin
      if (!por_n) strap_q <= pad_in;
   end
endmodule

// File: rtl/pad_oe_ctrl.sv
module pad_oe_ctrl #(
   parameter int unsigned PAD_W  = 5,
   parameter int unsigned STOP_W = 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              desktop,
   output logic [PAD_W-1:0]  pad_oe,
   output logic [STOP_W-1:0] stop_oe
);
   logic drive_q;

   generate
      if (STOP_W < 1) begin : g_bad_stop
         $error("pad_oe_ctrl: STOP_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) drive_q <= 1'b0;
      else        drive_q <= 1'b1;
   end

   assign pad_oe  = {PAD_W{drive_q}};
   assign stop_oe = {STOP_W{drive_q & desktop}};
endmodule

// File: rtl/freq_select.sv
module freq_select #(
   parameter int unsigned FS_W      = 3,
   parameter bit          RB_INVERT = 1'b1
) (
   input  logic [FS_W-1:0] strap_fs,
   input  logic            src_sw,
   input  logic [FS_W-1:0] sw_fs,
   output logic [FS_W-1:0] code,
   output logic [FS_W-1:0] readback
);
   generate
      if (FS_W < 1 || FS_W > 8) begin : g_bad_fs
         $error("freq_select: FS_W out of range");
      end
      if (RB_INVERT) begin : g_rb_inv
         assign readback = ~strap_fs;
      end else begin : g_rb_dir
         assign readback = strap_fs;
      end
   endgenerate

   always_comb begin
      code = src_sw ? sw_fs : strap_fs;
   end
endmodule

// File: rtl/boot_strap_select.sv
module boot_strap_select #(
   parameter int unsigned FS_W   = 3,
   parameter int unsigned STOP_W = 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic [FS_W+1:0]   pad_in,
   input  logic              cfg_src_sw,
   input  logic [FS_W-1:0]   cfg_freq_sw,
   output logic [FS_W+1:0]   pad_oe,
   output logic [STOP_W-1:0] stop_pin_oe,
   output logic [FS_W-1:0]   freq_code,
   output logic [FS_W-1:0]   fs_rb_n,
   output logic              desktop_mode,
   output logic              cpu_lowv
);
   import strap_pkg::*;

   localparam int unsigned PAD_W = pad_width(FS_W);
   localparam int unsigned M_POS = mode_pos(FS_W);
   localparam int unsigned S_POS = supply_pos(FS_W);

   logic [PAD_W-1:0] strap_q;

   strap_latch #(.W(PAD_W)) u_latch (
      .clk     (clk),
      .por_n   (por_n),
      .pad_in  (pad_in),
      .strap_q (strap_q)
   );

   assign desktop_mode = strap_q[M_POS];
   assign cpu_lowv     = strap_q[S_POS];

   pad_oe_ctrl #(.PAD_W(PAD_W), .STOP_W(STOP_W)) u_oe (
      .clk     (clk),
      .por_n   (por_n),
      .desktop (strap_q[M_POS]),
      .pad_oe  (pad_oe),
      .stop_oe (stop_pin_oe)
   );

   freq_select #(.FS_W(FS_W), .RB_INVERT(1'b1)) u_fsel (
      .strap_fs (strap_q[FS_W-1:0]),
      .src_sw   (cfg_src_sw),
      .sw_fs    (cfg_freq_sw),
      .code     (freq_code),
      .readback (fs_rb_n)
   );
endmodule

// File: rtl/boot_strap_select_chk.sv
module boot_strap_select_chk #(
   parameter int unsigned FS_W   = 3,
   parameter int unsigned STOP_W = 2
) (
   input logic              clk,
   input logic              por_n,
   input logic [FS_W+1:0]   pad_in,
   input logic              cfg_src_sw,
   input logic [FS_W-1:0]   cfg_freq_sw,
   input logic [FS_W+1:0]   pad_oe,
   input logic [STOP_W-1:0] stop_pin_oe,
   input logic [FS_W-1:0]   freq_code,
   input logic [FS_W-1:0]   fs_rb_n,
   input logic              desktop_mode,
   input logic              cpu_lowv
);
   AST_OE_OFF_IN_RESET: assert property (@(posedge clk)
      !por_n |-> (pad_oe == '0 && stop_pin_oe == '0)) else $error("oe in reset"); // R1

   AST_OE_FIRST_EDGE_OFF: assert property (@(posedge clk) disable iff (!por_n)
      !$past(por_n) |-> pad_oe == '0) else $error("oe early"); // R2

   AST_OE_ON_AFTER: assert property (@(posedge clk) disable iff (!por_n)
      $past(por_n) |-> pad_oe == '1) else $error("oe late"); // R2

   AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
      $past(por_n) |-> ($stable(fs_rb_n) && $stable(desktop_mode) && $stable(cpu_lowv)))
      else $error("strap moved"); // R4

   AST_SW_SOURCE: assert property (@(posedge clk) disable iff (!por_n)
      cfg_src_sw |-> freq_code == cfg_freq_sw) else $error("sw code"); // R6

   AST_STRAP_SOURCE: assert property (@(posedge clk) disable iff (!por_n)
      !cfg_src_sw |-> freq_code == ~fs_rb_n) else $error("strap code"); // R5

   AST_STOP_MODE: assert property (@(posedge clk) disable iff (!por_n)
      (stop_pin_oe != '0) |-> (desktop_mode && $onehot0(~stop_pin_oe) && stop_pin_oe == '1))
      else $error("stop oe"); // R8
endmodule

bind boot_strap_select boot_strap_select_chk #(.FS_W(FS_W), .STOP_W(STOP_W)) u_chk (.*);

// File: tb/boot_strap_select_tb.sv
module boot_strap_select_tb;
   localparam int CLK_P = 10;
   localparam int NV    = 8;
   // entry: {strap[4:0], src, sw[2:0]}
   localparam logic [8:0] VEC [NV] = '{
      {5'b00000, 1'b0, 3'b101},
      {5'b11111, 1'b0, 3'b000},
      {5'b01010, 1'b1, 3'b011},
      {5'b10101, 1'b1, 3'b111},
      {5'b01111, 1'b0, 3'b010},
      {5'b10000, 1'b1, 3'b000},
      {5'b00111, 1'b0, 3'b110},
      {5'b11000, 1'b1, 3'b100}
   };

   logic       clk = 1'b0;
   logic       por_n = 1'b1;
   logic [4:0] pad_in = '0;
   logic       cfg_src_sw = 1'b0;
   logic [2:0] cfg_freq_sw = '0;
   logic [4:0] pad_oe;
   logic [1:0] stop_pin_oe;
   logic [2:0] freq_code, fs_rb_n;
   logic       desktop_mode, cpu_lowv;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   boot_strap_select u_dut (
      .clk(clk), .por_n(por_n), .pad_in(pad_in), .cfg_src_sw(cfg_src_sw),
      .cfg_freq_sw(cfg_freq_sw), .pad_oe(pad_oe), .stop_pin_oe(stop_pin_oe),
      .freq_code(freq_code), .fs_rb_n(fs_rb_n), .desktop_mode(desktop_mode),
      .cpu_lowv(cpu_lowv)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   // Hold reset with the given pad pattern, release at a falling edge.
   task automatic do_por(input logic [4:0] strap);
      @(negedge clk);
      por_n  = 1'b0;
      pad_in = strap;
      repeat (3) @(negedge clk);
      chk("R1 oe in reset", {3'b0, pad_oe}, 8'h00);
      chk("R1 stop oe in reset", {6'b0, stop_pin_oe}, 8'h00);
   endtask

   task automatic check_straps(input logic [4:0] s, input logic src, input logic [2:0] sw);
      chk("R7 readback", {5'b0, fs_rb_n}, {5'b0, ~s[2:0]});
      chk("R8 mode", {7'b0, desktop_mode}, {7'b0, s[3]});
      chk("R9 supply", {7'b0, cpu_lowv}, {7'b0, s[4]});
      chk(src ? "R6 sw code" : "R5 strap code", {5'b0, freq_code},
          {5'b0, (src ? sw : s[2:0])});
      chk("R8 stop oe", {6'b0, stop_pin_oe}, {6'b0, {2{s[3]}}});
   endtask

   initial begin
      #1 por_n = 1'b0;
      for (int i = 0; i < NV; i++) begin
         logic [4:0] s;
         s = VEC[i][8:4];
         do_por(s);
         por_n       = 1'b1;
         pad_in      = ~s;          // pads turn to outputs: must not be captured
         cfg_src_sw  = VEC[i][3];
         cfg_freq_sw = VEC[i][2:0];
         #1 chk("R2 oe before first edge", {3'b0, pad_oe}, 8'h00);
         @(negedge clk);
         chk("R2 oe after first edge", {3'b0, pad_oe}, 8'h1f);
         check_straps(s, VEC[i][3], VEC[i][2:0]);
         pad_in = 5'b10110 ^ s;
         repeat (2) @(negedge clk);
         chk("R4 pad ignored", {3'b0, ~fs_rb_n, desktop_mode, cpu_lowv},
             {3'b0, s[2:0], s[3], s[4]});
         chk("R2 oe held", {3'b0, pad_oe}, 8'h1f);
      end

      // R3: last pattern before release wins.
      @(negedge clk);
      por_n = 1'b0; pad_in = 5'b11111;
      repeat (2) @(negedge clk);
      pad_in = 5'b01001;
      @(negedge clk);
      por_n = 1'b1; pad_in = 5'b00000; cfg_src_sw = 1'b0;
      @(negedge clk);
      chk("R3 last capture", {3'b0, ~fs_rb_n, desktop_mode, cpu_lowv}, {3'b0, 3'b001, 1'b1, 1'b0});
      chk("R5 strap code", {5'b0, freq_code}, 8'd1);

      // R6: live source switch, same cycle.
      cfg_freq_sw = 3'b110; cfg_src_sw = 1'b1;
      #1 chk("R6 switch to sw", {5'b0, freq_code}, 8'd6);
      cfg_src_sw = 1'b0;
      #1 chk("R6 switch back", {5'b0, freq_code}, 8'd1);

      // R8: mobile mode keeps stop pins as inputs.
      do_por(5'b00110);
      por_n = 1'b1;
      @(negedge clk);
      chk("R8 mobile stop oe", {6'b0, stop_pin_oe}, 8'h00);
      chk("R2 oe on in mobile", {3'b0, pad_oe}, 8'h1f);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule